// File: doc/BRIEF.md
# Multi-Lane Bit Error Counter and First-Failure Logger

This block watches a parallel link port of several lanes, one word per clock. In every cycle where the compare strobe is high, it compares the received lane bits against the expected lane bits, lane by lane. Lanes marked absent by a presence mask are skipped. The number of lanes that disagree in that cycle is added to a port-wide error total. The total stops at its maximum value and never wraps.

The block also records the lane of the first error. In the first cycle with any failing lane, it stores the number of the highest failing lane and raises a flag. That lane number then stays fixed until a synchronous clear. The clear zeroes the total, the lane number and the flag, and it wins over any compare in the same cycle.

A link test engine uses the block to measure bit errors while a pattern is received. It reads the total and the first failing lane after the run.

Top module: `lane_err_logger`

## Requirements
- R1: In each cycle with `cmp_valid` high and no clear, `err_count` grows by the number of lanes i with `lane_en[i]`=1 and `rx_bits[i]`≠`exp_bits[i]`. Bit i of each vector belongs to lane i. The new value shows after the next rising clock edge.
- R2: `err_count` is 10 bits wide and saturates at 1023. An addition that would pass 1023 leaves it at 1023.
- R3: In the first cycle with at least one failing lane, `first_lane` takes the binary number of the highest-numbered failing lane (0 to 13), and `lane_logged` goes to 1.
- R4: Once `lane_logged` is 1, `first_lane` and `lane_logged` keep their values until a clear or a reset, whatever errors follow.
- R5: A lane with `lane_en[i]`=0 never adds to `err_count` and is never logged in `first_lane`.
- R6: In a cycle with `cmp_valid` low, no output changes.
- R7: With `clr` high at a rising edge, `err_count`, `first_lane` and `lane_logged` become 0. This holds even when a failing compare happens in the same cycle.
- R8: While `rst_n` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the count and the log |
| cmp_valid | input | 1 | Compare the lanes in this cycle |
| rx_bits | input | 14 | Received bit per lane |
| exp_bits | input | 14 | Expected bit per lane |
| lane_en | input | 14 | Lane present mask |
| err_count | output | 10 | Saturating error total |
| first_lane | output | 4 | Lane number of the first error |
| lane_logged | output | 1 | A lane number has been logged |

## Verification
The bench drives cycles where several lanes fail at once. A design that added only one per failing cycle would give a total that is too low. It drives a first failing cycle in which lanes 0 and 13 both fail. A design that logged the lowest lane, or that logged a lane from a later cycle, would report the wrong number. It runs the total to 1022 and then adds three more errors, so a counter that wrapped would show a small value instead of 1023. It also drives failures on masked lanes, failures while the strobe is low, and a clear in the same cycle as a failing compare. A design that ignored the mask, the strobe or the clear priority would show a count or a log that is not zero.

// File: rtl/lane_err_logger.sv
module lane_err_logger #(
  parameter int LANES = 14,
  parameter int CNT_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmp_valid,
  input  logic [LANES-1:0] rx_bits,
  input  logic [LANES-1:0] exp_bits,
  input  logic [LANES-1:0] lane_en,
  output logic [CNT_W-1:0] err_count,
  output logic [IDX_W-1:0] first_lane,
  output logic             lane_logged
);
  localparam int PW = $clog2(LANES + 1);
  localparam logic [CNT_W:0] MAXC = {1'b0, {CNT_W{1'b1}}};

  logic [LANES-1:0] fail;
  logic [PW-1:0]    nfail;
  logic [IDX_W-1:0] top_idx;
  logic [CNT_W:0]   sum;

  assign fail = (rx_bits ^ exp_bits) & lane_en & {LANES{cmp_valid}};

  always_comb begin
    nfail   = '0;
    top_idx = '0;
    for (int i = 0; i < LANES; i++) begin
      nfail = nfail + PW'(fail[i]);
      if (fail[i]) top_idx = IDX_W'(i);
    end
  end

  assign sum = {1'b0, err_count} + (CNT_W+1)'(nfail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count   <= '0;
      first_lane  <= '0;
      lane_logged <= 1'b0;
    end else if (clr) begin
      err_count   <= '0;
      first_lane  <= '0;
      lane_logged <= 1'b0;
    end else begin
      err_count <= (sum > MAXC) ? MAXC[CNT_W-1:0] : sum[CNT_W-1:0];
      if (!lane_logged && |fail) begin
        first_lane  <= top_idx;
        lane_logged <= 1'b1;
      end
    end
  end
endmodule

module lane_err_logger_chk #(
  parameter int LANES = 14,
  parameter int CNT_W = 10,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             cmp_valid,
  input logic [LANES-1:0] rx_bits,
  input logic [LANES-1:0] exp_bits,
  input logic [LANES-1:0] lane_en,
  input logic [CNT_W-1:0] err_count,
  input logic [IDX_W-1:0] first_lane,
  input logic             lane_logged
);
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_count == '0) && (first_lane == '0) && !lane_logged);

  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count >= $past(err_count)));

  p_step_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_count - $past(err_count)) <= CNT_W'(LANES)));

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_logged && !clr) |=> lane_logged && $stable(first_lane));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !clr) |=> $stable(err_count) && $stable(lane_logged) && $stable(first_lane));

  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((((rx_bits ^ exp_bits) & lane_en) == '0) && !clr) |=> $stable(err_count) && $stable(lane_logged));

  p_lane_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_logged |-> (first_lane < IDX_W'(LANES)));
endmodule

bind lane_err_logger lane_err_logger_chk #(.LANES(LANES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/lane_err_logger_test.sv
module lane_err_logger_test;
  typedef struct packed {
    logic        v;
    logic [13:0] en;
    logic [13:0] rx;
    logic [13:0] ex;
    logic [9:0]  cnt;
    logic [3:0]  ln;
    logic        lg;
  } vec_t;

  localparam int N = 8;
  localparam vec_t TBL [N] = '{
    '{1'b1, 14'h3FFF, 14'h0000, 14'h0000, 10'd0,  4'd0, 1'b0},
    '{1'b1, 14'h3FFF, 14'h0028, 14'h0000, 10'd2,  4'd5, 1'b1},
    '{1'b1, 14'h3FFF, 14'h3FFF, 14'h0000, 10'd16, 4'd5, 1'b1},
    '{1'b0, 14'h3FFF, 14'h3FFF, 14'h0000, 10'd16, 4'd5, 1'b1},
    '{1'b1, 14'h00FF, 14'h3F00, 14'h0000, 10'd16, 4'd5, 1'b1},
    '{1'b1, 14'h00FF, 14'h3F0F, 14'h0003, 10'd18, 4'd5, 1'b1},
    '{1'b1, 14'h3FFF, 14'h2AAA, 14'h2AAA, 10'd18, 4'd5, 1'b1},
    '{1'b1, 14'h3FFF, 14'h1555, 14'h2AAA, 10'd32, 4'd5, 1'b1}
  };

  logic clk = 0, rst_n = 0, clr = 0, cmp_valid = 0;
  logic [13:0] rx_bits = '0, exp_bits = '0, lane_en = '0;
  logic [9:0] err_count;
  logic [3:0] first_lane;
  logic lane_logged;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  lane_err_logger uut (.*);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(logic c, logic v, logic [13:0] en, logic [13:0] rx, logic [13:0] ex);
    clr = c; cmp_valid = v; lane_en = en; rx_bits = rx; exp_bits = ex;
    @(negedge clk);
  endtask

  task automatic outs(string r, int c, int l, int g);
    chk({r, " count"}, err_count, c);
    chk({r, " lane"}, first_lane, l);
    chk({r, " logged"}, lane_logged, g);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    outs("R8 reset", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R4 R5 R6 walked through the table
    for (int i = 0; i < N; i++) begin
      step(1'b0, TBL[i].v, TBL[i].en, TBL[i].rx, TBL[i].ex);
      outs($sformatf("R1/R3/R4/R5/R6 row %0d", i), TBL[i].cnt, TBL[i].ln, TBL[i].lg);
    end

    // R7: clear together with a failing compare
    step(1'b1, 1'b1, 14'h3FFF, 14'h3FFF, 14'h0000);
    outs("R7 clear priority", 0, 0, 0);

    // R3: lanes 0 and 13 fail together first, highest is logged
    step(1'b0, 1'b1, 14'h3FFF, 14'h2001, 14'h0000);
    outs("R3 highest lane", 2, 13, 1);
    step(1'b0, 1'b1, 14'h3FFF, 14'h0001, 14'h0000);
    outs("R4 frozen", 3, 13, 1);

    // R5: masked lane 13 is not logged
    step(1'b1, 1'b0, 14'h0000, 14'h0000, 14'h0000);
    step(1'b0, 1'b1, 14'h1FFF, 14'h2001, 14'h0000);
    outs("R5 masked lane not logged", 1, 0, 1);

    // R2: saturation
    step(1'b1, 1'b0, 14'h0000, 14'h0000, 14'h0000);
    for (int k = 0; k < 73; k++) step(1'b0, 1'b1, 14'h3FFF, 14'h3FFF, 14'h0000);
    chk("R2 pre-saturation count", err_count, 1022);
    step(1'b0, 1'b1, 14'h3FFF, 14'h0007, 14'h0000);
    chk("R2 saturate", err_count, 1023);
    step(1'b0, 1'b1, 14'h3FFF, 14'h3FFF, 14'h0000);
    chk("R2 stays saturated", err_count, 1023);
    step(1'b0, 1'b0, 14'h3FFF, 14'h3FFF, 14'h0000);
    chk("R6 idle at max", err_count, 1023);

    // R8: asynchronous reset mid-run
    #2 rst_n = 0;
    #1 outs("R8 mid-run reset", 0, 0, 0);
    @(negedge clk); rst_n = 1;
    step(1'b0, 1'b0, 14'h0000, 14'h0000, 14'h0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule